// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a single-clock pipelined static RAM with a burst address generator. Every synchronous input is captured in a register on the rising clock edge. The registered controls then drive one access of an internal array, and read data passes through one more output register. A burst is opened by either of two address strobes. The two low address bits are then stepped by a 2-bit counter whenever the advance input is asserted. The step order is linear or XOR-interleaved, and it is chosen by a mode input that is sampled every cycle.

The array is organised as byte lanes. A write can touch any subset of the lanes through a byte-write enable and per-lane enables, or it can touch all of them through a global write that overrides those enables. The chip is selected by three enables of mixed polarity. When a start strobe arrives while the chip is not selected, the block deselects. The data output keeps driving for one more cycle to finish the read already in the pipeline, and then it releases. An asynchronous output enable gates only the drive indication. Data that is not driven stands for high impedance.

Top module: `psram_top`

## Requirements
- R1: After reset the output is undriven and no burst is open. An advance input with no prior start causes no access.
- R2: Read data for an address captured at edge k is on `rdata`, with `rdata_drive` high, after edge k+2. A write or idle cycle captured at edge k leaves `rdata_drive` low after edge k+2.
- R3: A start happens when `adsp_n` is low with `ce_n` low (always a read), or when `adsc_n` is low. An ADSC start is a write if any lane is enabled and a read otherwise. `adsp_n` is ignored while `ce_n` is high. If both strobes qualify together, the access is a read.
- R4: With `mode`=0 the low two address bits of beat n are (start + n) mod 4. Address bits above bit 1 stay at the start value for the whole burst.
- R5: With `mode`=1 the low two address bits of beat n are start XOR n.
- R6: `adv_n` is ignored in a start cycle. A continuation cycle with `adv_n` high repeats the current address. The offset wraps after four beats back to the start offset.
- R7: Lane i is data bits [9i+8:9i]. When `gw_n` is high, lane i is written when `bwe_n` is low and `bw_n[i]` is low. The other lanes keep their contents.
- R8: When `gw_n` is low, all four lanes are written, regardless of `bwe_n` and `bw_n`.
- R9: A read of an address in the cycle right after a write to it returns the new data.
- R10: The chip is selected only when `ce_n`=0, `ce2`=1 and `ce2_n`=0. A start while the chip is not selected closes the burst. The output stays driven for one cycle more, then goes undriven.
- R11: `oe_n` high forces `rdata_drive` low at once. It has no effect on the burst sequence or on the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Access address |
| wdata | input | LANES*LW | Write data |
| adsp_n | input | 1 | Processor-side start strobe, active low |
| adsc_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| ce_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | LANES*LW | Registered read data |
| rdata_drive | output | 1 | High when `rdata` is driven |

## Verification
If the burst counter or its base is wrong, a beat reads the wrong word, and this shows on `rdata` two edges after the faulty step. A wrong lane decode is seen only when that word is read back, which can be several cycles later. A fault in the deselect or drive path shows on `rdata_drive` at the exact edge where the expected drive level changes. The bench's reference model checks both ports on every cycle, so each fault is reported at the first port cycle it touches.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_op_e;
endpackage

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
  import psram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic                adsp_n,
  input  logic                adsc_n,
  input  logic                adv_n,
  input  logic                gw_n,
  input  logic                bwe_n,
  input  logic [LANES-1:0]    bw_n,
  input  logic                ce_n,
  input  logic                ce2,
  input  logic                ce2_n,
  input  logic                mode,
  output acc_op_e             acc_op,
  output logic [AW-1:0]       acc_addr,
  output logic [LANES-1:0]    acc_be,
  output logic [LANES*LW-1:0] acc_wdata
);
  localparam int DW = LANES * LW;
  localparam int UW = AW - 2;

  // input capture stage
  logic [AW-1:0]    r_addr;
  logic [DW-1:0]    r_wdata;
  logic             r_adsp_n, r_adsc_n, r_adv_n, r_gw_n, r_bwe_n;
  logic [LANES-1:0] r_bw_n;
  logic             r_ce_n, r_ce2, r_ce2_n, r_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_adsp_n <= 1'b1;
      r_adsc_n <= 1'b1;
      r_adv_n  <= 1'b1;
      r_gw_n   <= 1'b1;
      r_bwe_n  <= 1'b1;
      r_bw_n   <= '1;
      r_ce_n   <= 1'b1;
      r_ce2    <= 1'b0;
      r_ce2_n  <= 1'b1;
      r_mode   <= 1'b0;
      r_addr   <= '0;
      r_wdata  <= '0;
    end else begin
      r_adsp_n <= adsp_n;
      r_adsc_n <= adsc_n;
      r_adv_n  <= adv_n;
      r_gw_n   <= gw_n;
      r_bwe_n  <= bwe_n;
      r_bw_n   <= bw_n;
      r_ce_n   <= ce_n;
      r_ce2    <= ce2;
      r_ce2_n  <= ce2_n;
      r_mode   <= mode;
      r_addr   <= addr;
      r_wdata  <= wdata;
    end
  end

  // burst state
  logic          active_q;
  logic [UW-1:0] upper_q;
  logic [1:0]    base_q, cnt_q;

  logic             sel, p_start, c_start, start, step;
  logic [LANES-1:0] lanes;
  logic [1:0]       cnt_nx, off;

  always_comb begin
    sel     = !r_ce_n && r_ce2 && !r_ce2_n;
    p_start = !r_adsp_n && !r_ce_n;
    c_start = !r_adsc_n && !p_start;
    start   = p_start || c_start;
    step    = !r_adv_n;
    if (!r_gw_n)       lanes = '1;
    else if (!r_bwe_n) lanes = ~r_bw_n;
    else               lanes = '0;
    cnt_nx = cnt_q + {1'b0, step};
    off    = r_mode ? (base_q ^ cnt_nx) : (base_q + cnt_nx);

    acc_op   = ACC_NONE;
    acc_addr = r_addr;
    acc_be   = '0;
    if (start) begin
      if (sel) begin
        if (p_start || lanes == '0) acc_op = ACC_READ;
        else begin
          acc_op = ACC_WRITE;
          acc_be = lanes;
        end
      end
    end else if (active_q) begin
      acc_addr = {upper_q, off};
      if (lanes == '0) acc_op = ACC_READ;
      else begin
        acc_op = ACC_WRITE;
        acc_be = lanes;
      end
    end
  end

  assign acc_wdata = r_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      upper_q  <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= sel;
      upper_q  <= r_addr[AW-1:2];
      base_q   <= r_addr[1:0];
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_nx;
    end
  end

  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    (active_q && !start) |-> acc_addr[AW-1:2] == $past(acc_addr[AW-1:2]));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
    (active_q && !start && step && !r_mode && $past(!r_mode))
      |-> acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1);

  assert_hold_no_adv_R6: assert property (@(posedge clk) disable iff (rst)
    (active_q && !start && !step && r_mode == $past(r_mode))
      |-> acc_addr == $past(acc_addr));

  assert_global_all_lanes_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_op == ACC_WRITE && !r_gw_n) |-> (&acc_be));
endmodule

// File: rtl/psram_array.sv
module psram_array
  import psram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  acc_op_e             op,
  input  logic [AW-1:0]       addr,
  input  logic [LANES-1:0]    be,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rd_data,
  output logic                rd_vld
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (op == ACC_WRITE) begin
      for (int i = 0; i < LANES; i++)
        if (be[i]) mem[addr][i*LW +: LW] <= wdata[i*LW +: LW];
    end
    if (op == ACC_READ) rd_data <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= (op == ACC_READ);
  end
endmodule

// File: rtl/psram_outreg.sv
module psram_outreg #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_vld,
  input  logic [DW-1:0] rd_data,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          out_vld,
  output logic          dout_drive
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      dout    <= '0;
    end else begin
      out_vld <= rd_vld;
      if (rd_vld) dout <= rd_data;
    end
  end

  assign dout_drive = out_vld && !oe_n;

  assert_drive_needs_read_R2: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(rd_vld));
endmodule

// File: rtl/psram_top.sv
module psram_top
  import psram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic                adsp_n,
  input  logic                adsc_n,
  input  logic                adv_n,
  input  logic                gw_n,
  input  logic                bwe_n,
  input  logic [LANES-1:0]    bw_n,
  input  logic                ce_n,
  input  logic                ce2,
  input  logic                ce2_n,
  input  logic                mode,
  input  logic                oe_n,
  output logic [LANES*LW-1:0] rdata,
  output logic                rdata_drive
);
  localparam int DW = LANES * LW;

  acc_op_e          acc_op;
  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] acc_be;
  logic [DW-1:0]    acc_wdata, arr_data;
  logic             arr_vld, out_vld;

  psram_burst_ctrl #(.AW(AW), .LANES(LANES), .LW(LW)) ctrl_i (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .mode(mode),
    .acc_op(acc_op), .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata)
  );

  psram_array #(.AW(AW), .LANES(LANES), .LW(LW)) array_i (
    .clk(clk), .rst(rst), .op(acc_op), .addr(acc_addr), .be(acc_be),
    .wdata(acc_wdata), .rd_data(arr_data), .rd_vld(arr_vld)
  );

  psram_outreg #(.DW(DW)) out_i (
    .clk(clk), .rst(rst), .rd_vld(arr_vld), .rd_data(arr_data), .oe_n(oe_n),
    .dout(rdata), .out_vld(out_vld), .dout_drive(rdata_drive)
  );

  assert_adsp_read_only_R3: assert property (@(posedge clk) disable iff (rst)
    (!adsp_n && !ce_n) |=> (acc_op != ACC_WRITE));

  assert_deselect_release_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_op != ACC_READ) |=> ##1 !out_vld);
endmodule

// File: tb/psram_top_tb_top.sv
module psram_top_tb_top;
  localparam int AW = 8, LANES = 4, LW = 9, DW = 36;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic adsp_n = 1, adsc_n = 1, adv_n = 1, gw_n = 1, bwe_n = 1;
  logic [LANES-1:0] bw_n = '1;
  logic ce_n = 0, ce2 = 1, ce2_n = 0, mode = 0, oe_n = 0;
  logic [DW-1:0] rdata;
  logic rdata_drive;

  always #2 clk = ~clk;

  psram_top #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .mode(mode), .oe_n(oe_n),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  int n_checks = 0, n_fail = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  // ---------------- reference model ----------------
  logic [DW-1:0] m_mem [256];
  logic [3:0]    m_kn  [256];
  int  c_addr, c_adsp_n, c_adsc_n, c_adv_n, c_gw_n, c_bwe_n, c_bw_n;
  int  c_ce_n, c_ce2, c_ce2_n, c_mode;
  logic [DW-1:0] c_wdata;
  bit  m_active;
  int  m_up, m_base, m_cnt;
  bit  p_rd, e_drive;
  logic [DW-1:0] p_data, e_data;
  logic [3:0] p_mask, e_mask;

  initial for (int i = 0; i < 256; i++) m_kn[i] = 4'h0;

  always @(posedge clk) begin
    if (rst) begin
      e_drive = 0; p_rd = 0; m_active = 0; m_cnt = 0;
      c_adsp_n = 1; c_adsc_n = 1; c_ce_n = 1; c_ce2 = 0; c_ce2_n = 1;
      c_adv_n = 1; c_gw_n = 1; c_bwe_n = 1; c_bw_n = 15; c_mode = 0;
      c_addr = 0; c_wdata = '0;
    end else begin
      bit sel, ps, cs, doacc, isw;
      int ln, a, off;
      e_drive = p_rd; e_data = p_data; e_mask = p_mask;
      p_rd = 0;
      sel = (c_ce_n == 0) && (c_ce2 == 1) && (c_ce2_n == 0);
      ps = (c_adsp_n == 0) && (c_ce_n == 0);
      cs = (c_adsc_n == 0) && !ps;
      ln = (c_gw_n == 0) ? 15 : ((c_bwe_n == 0) ? (~c_bw_n & 15) : 0);
      doacc = 0; isw = 0; a = 0;
      if (ps || cs) begin
        m_active = sel; m_up = c_addr / 4; m_base = c_addr % 4; m_cnt = 0;
        if (sel) begin doacc = 1; a = c_addr; isw = cs && (ln != 0); end
      end else if (m_active) begin
        if (c_adv_n == 0) m_cnt = (m_cnt + 1) % 4;
        off = c_mode ? (m_base ^ m_cnt) : ((m_base + m_cnt) % 4);
        a = m_up * 4 + off; doacc = 1; isw = (ln != 0);
      end
      if (doacc) begin
        if (isw) begin
          for (int i = 0; i < 4; i++) if (ln[i]) begin
            m_mem[a][i*9 +: 9] = c_wdata[i*9 +: 9];
            m_kn[a][i] = 1'b1;
          end
        end else begin
          p_rd = 1; p_data = m_mem[a]; p_mask = m_kn[a];
        end
      end
      c_addr = addr; c_wdata = wdata; c_adsp_n = adsp_n; c_adsc_n = adsc_n;
      c_adv_n = adv_n; c_gw_n = gw_n; c_bwe_n = bwe_n; c_bw_n = bw_n;
      c_ce_n = ce_n; c_ce2 = ce2; c_ce2_n = ce2_n; c_mode = mode;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit xd;
      logic [DW-1:0] bm;
      xd = e_drive && !oe_n;
      n_checks++;
      if (rdata_drive !== xd) begin
        n_fail++;
        $display("FAIL %s drive actual=%0b expected=%0b t=%0t", tag, rdata_drive, xd, $time);
      end else if (xd) begin
        for (int i = 0; i < 4; i++) bm[i*9 +: 9] = {9{e_mask[i]}};
        n_checks++;
        if ((rdata & bm) !== (e_data & bm)) begin
          n_fail++;
          $display("FAIL %s data actual=%h expected=%h t=%0t", tag, rdata & bm, e_data & bm, $time);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(); @(posedge clk); #1; endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
    ce_n = 0; ce2 = 1; ce2_n = 0;
  endtask

  function automatic logic [DW-1:0] pat(int a, int k);
    return {4{a[4:0], k[3:0]}} ^ 36'h5A3C96E1F;
  endfunction

  task automatic wburst(int a, int k);
    idle(); adsc_n = 0; gw_n = 0; addr = a[7:0]; wdata = pat(a, k); tick();
    for (int i = 1; i < 4; i++) begin
      idle(); adv_n = 0; gw_n = 0; wdata = pat(a, k + i); tick();
    end
    idle(); tick();
  endtask

  task automatic rburst(int a, int beats, bit m);
    idle(); mode = m; adsp_n = 0; adv_n = 0; addr = a[7:0]; tick();
    for (int i = 1; i < beats; i++) begin idle(); adv_n = 0; tick(); end
    idle(); tick(); tick(); tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    // R1: undriven after reset, advance without a start does nothing
    tag = "R1";
    @(negedge clk); n_checks++;
    if (rdata_drive !== 1'b0) begin n_fail++; $display("FAIL R1 drive actual=%0b expected=0", rdata_drive); end
    tick(); adv_n = 0; tick(); tick(); idle(); tick(); tick(); tick();

    tag = "R8"; wburst(16, 0);
    tag = "R4"; rburst(18, 4, 0);
    tag = "R5"; rburst(17, 4, 1);
    tag = "R6"; rburst(18, 6, 0);
    // R6: continuation without advance holds the address
    tag = "R6";
    idle(); adsp_n = 0; addr = 8'd16; tick();
    idle(); tick(); idle(); adv_n = 0; tick(); idle(); tick(); tick(); tick();

    // R7: lane writes over a known word
    tag = "R7";
    idle(); adsc_n = 0; gw_n = 0; addr = 8'd32; wdata = '0; tick();
    idle(); adsc_n = 0; bwe_n = 0; bw_n = 4'b1010; addr = 8'd32; wdata = '1; tick();
    idle(); adsc_n = 0; bwe_n = 1; bw_n = 4'b0000; addr = 8'd33; wdata = 36'h123456789; tick();
    rburst(32, 2, 0);
    // R8: global write ignores the lane enables
    tag = "R8";
    idle(); adsc_n = 0; gw_n = 0; bwe_n = 1; bw_n = 4'b1111; addr = 8'd33; wdata = 36'h9ABCDEF01; tick();
    rburst(33, 1, 0);
    // R9: read immediately after write
    tag = "R9";
    idle(); adsc_n = 0; gw_n = 0; addr = 8'd48; wdata = 36'hFEDCBA987; tick();
    idle(); adsp_n = 0; addr = 8'd48; tick(); idle(); tick(); tick(); tick();
    // R3: ADSP ignored with ce_n high; both strobes give a read
    tag = "R3";
    idle(); adsp_n = 0; addr = 8'd16; tick();
    idle(); ce_n = 1; adsp_n = 0; adv_n = 0; addr = 8'd40; tick();
    idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 8'd17; wdata = '0; tick();
    idle(); tick(); tick(); tick();
    // R10: deselect during a burst through each enable
    tag = "R10";
    for (int e = 0; e < 3; e++) begin
      idle(); adsp_n = 0; addr = 8'd16; tick();
      idle(); adv_n = 0; tick();
      idle(); adsc_n = 0;
      if (e == 0) ce2 = 0; else if (e == 1) ce2_n = 1; else ce_n = 1;
      tick();
      idle(); adv_n = 0; tick(); idle(); tick(); tick();
    end
    // R11: oe_n mid-burst leaves the sequence intact
    tag = "R11";
    idle(); adsp_n = 0; addr = 8'd16; tick();
    idle(); adv_n = 0; tick();
    oe_n = 1; adv_n = 0; tick(); tick();
    oe_n = 0; idle(); adv_n = 0; tick(); idle(); tick(); tick(); tick();
    // R2: random traffic against the model
    tag = "R2";
    for (int i = 0; i < 800; i++) begin
      adsp_n = ($urandom % 6) != 0; adsc_n = ($urandom % 5) != 0;
      adv_n = $urandom % 2; gw_n = ($urandom % 4) != 0; bwe_n = $urandom % 2;
      bw_n = 4'($urandom); ce_n = ($urandom % 10) == 0; ce2 = ($urandom % 10) != 0;
      ce2_n = ($urandom % 10) == 0; mode = $urandom % 2; oe_n = ($urandom % 8) == 0;
      addr = 8'($urandom % 24); wdata = {4'($urandom), 32'($urandom)};
      tick();
    end
    idle(); oe_n = 0; tick(); tick(); tick();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1; n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule